// File: doc/BRIEF.md
# Magnetometer Result Latch with Read-Window Protection

This block sits between a three-axis measurement engine and the host-visible result registers. Each time the engine presents a finished sample, the block clamps every axis to the legal 16-bit output range and captures the three axes together with a sensor-overflow flag. It also keeps two status flags: a data-ready flag and an overrun flag that reports a lost sample.

The bus interface gives the block one strobe per register class. One strobe covers any measurement data register. A second covers the first status register, which holds data-ready in bit 0 and overrun in bit 1. A third covers the trailing status register, which holds the overflow flag in bit 3, a constant 1 in bit 2, and reads 04h after reset.

In continuous modes, reading a data register opens a read window. The window closes only when the trailing status register is read. While the window is open, the visible results stay frozen. A sample that completes during the window waits in a one-deep shadow buffer and is published when the window closes. If a newer sample arrives while the buffer is full, the older one is dropped and the loss is reported.

Top module: `mag_result_guard`

## Requirements
- R1: After reset, all axis outputs are 0, the first status byte is 00h and the trailing status byte is 04h.
- R2: When a sample is accepted outside a read window, the three axes, the overflow flag and data-ready=1 are visible on the outputs in the cycle after the sample pulse.
- R3: Each axis is saturated to the range -32752 to +32752 before it is stored.
- R4: A data-register read or a trailing-status read clears data-ready and overrun in the next cycle, unless a set condition occurs in the same cycle. A read of the first status register changes neither flag.
- R5: With continuous mode set, a data-register read opens a read window. While the window is open, samples do not change the axis outputs or the overflow flag.
- R6: A trailing-status read that closes a window with a buffered sample publishes that sample and sets data-ready in the next cycle.
- R7: In continuous mode, a sample accepted while data-ready is still 1 and not being read in that cycle sets overrun, which is bit 1 of the first status byte.
- R8: A second sample arriving during one window replaces the buffered one and sets overrun. Only the newest sample is published at close.
- R9: With continuous mode clear, a data read opens no window and overrun is never set.
- R10: The overflow flag is bit 3 of the trailing status byte. It changes only when the axis outputs are updated, and then takes the overflow bit of the published sample.
- R11: A sample arriving in the same cycle as the closing read is published directly. Any buffered sample is discarded, and overrun is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cont_mode | input | 1 | 1 selects continuous measurement behaviour |
| sample_vld | input | 1 | One-cycle pulse: a sample is complete |
| sample_x | input | IN_W | Raw signed X value |
| sample_y | input | IN_W | Raw signed Y value |
| sample_z | input | IN_W | Raw signed Z value |
| sample_ovf | input | 1 | Sensor overflow bit of the sample |
| rd_data | input | 1 | Host read of any measurement data register |
| rd_stat1 | input | 1 | Host read of the first status register |
| rd_stat2 | input | 1 | Host read of the trailing status register |
| x_out | output | AXIS_W | Published X axis |
| y_out | output | AXIS_W | Published Y axis |
| z_out | output | AXIS_W | Published Z axis |
| stat1 | output | 8 | First status byte {6'b0, overrun, data-ready} |
| stat2 | output | 8 | Trailing status byte {4'b0, overflow, 3'b100} |

## Verification
Every result of this block comes from a register one edge deep. Axis values, data-ready, overrun and the overflow flag are therefore due in the cycle after the sample pulse or read strobe that causes them. A buffered sample appears one cycle after the closing read. The bench drives each stimulus on a falling edge and samples one time unit after the next rising edge, so it compares results exactly one cycle after their cause. In the "no change" cases (a locked window, a first-status read), the same sample point shows whether the held value survived that single edge.

// File: rtl/mag_result_guard.sv
module mag_result_guard #(
  parameter int IN_W    = 18,
  parameter int AXIS_W  = 16,
  parameter int SAT_LIM = 32752
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cont_mode,
  input  logic              sample_vld,
  input  logic [IN_W-1:0]   sample_x,
  input  logic [IN_W-1:0]   sample_y,
  input  logic [IN_W-1:0]   sample_z,
  input  logic              sample_ovf,
  input  logic              rd_data,
  input  logic              rd_stat1,
  input  logic              rd_stat2,
  output logic [AXIS_W-1:0] x_out,
  output logic [AXIS_W-1:0] y_out,
  output logic [AXIS_W-1:0] z_out,
  output logic [7:0]        stat1,
  output logic [7:0]        stat2
);

  localparam logic signed [IN_W-1:0]   HI_IN  = IN_W'(SAT_LIM);
  localparam logic signed [IN_W-1:0]   LO_IN  = IN_W'(-SAT_LIM);
  localparam logic        [AXIS_W-1:0] HI_OUT = AXIS_W'(SAT_LIM);
  localparam logic        [AXIS_W-1:0] LO_OUT = AXIS_W'(-SAT_LIM);

  function automatic logic [AXIS_W-1:0] clamp(input logic [IN_W-1:0] raw);
    logic signed [IN_W-1:0] v;
    v = $signed(raw);
    if (v > HI_IN)      return HI_OUT;
    else if (v < LO_IN) return LO_OUT;
    else                return raw[AXIS_W-1:0];
  endfunction

  logic              lock_q, pend_v, drdy, dor, hofl;
  logic [AXIS_W-1:0] pend_x, pend_y, pend_z;
  logic              pend_ovf;

  wire rd_clr    = rd_data | rd_stat2;
  wire lock_open = lock_q & ~rd_stat2;
  wire take_now  = sample_vld & ~lock_open;
  wire take_pend = lock_q & rd_stat2 & pend_v & ~sample_vld;
  wire to_shadow = sample_vld & lock_open;
  wire skip      = cont_mode & ((take_now & drdy & ~rd_clr) | (sample_vld & lock_q & pend_v));

  wire unused_ok = rd_stat1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      pend_v   <= 1'b0;
      pend_x   <= '0;
      pend_y   <= '0;
      pend_z   <= '0;
      pend_ovf <= 1'b0;
      x_out    <= '0;
      y_out    <= '0;
      z_out    <= '0;
      hofl     <= 1'b0;
      drdy     <= 1'b0;
      dor      <= 1'b0;
    end else begin
      lock_q <= cont_mode & ~rd_stat2 & (lock_q | rd_data);
      pend_v <= cont_mode & (to_shadow | (pend_v & lock_open));
      if (to_shadow) begin
        pend_x   <= clamp(sample_x);
        pend_y   <= clamp(sample_y);
        pend_z   <= clamp(sample_z);
        pend_ovf <= sample_ovf;
      end
      if (take_now) begin
        x_out <= clamp(sample_x);
        y_out <= clamp(sample_y);
        z_out <= clamp(sample_z);
        hofl  <= sample_ovf;
      end else if (take_pend) begin
        x_out <= pend_x;
        y_out <= pend_y;
        z_out <= pend_z;
        hofl  <= pend_ovf;
      end
      drdy <= take_now | take_pend | (drdy & ~rd_clr);
      dor  <= skip | (dor & ~rd_clr);
    end
  end

  assign stat1 = {6'b0, dor, drdy};
  assign stat2 = {4'b0, hofl, 3'b100};

endmodule

// File: rtl/mag_result_guard_chk.sv
module mag_result_guard_chk #(
  parameter int AXIS_W  = 16,
  parameter int SAT_LIM = 32752
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cont_mode,
  input logic              sample_vld,
  input logic              rd_data,
  input logic              rd_stat2,
  input logic              lock_q,
  input logic              pend_v,
  input logic [AXIS_W-1:0] x_out,
  input logic [7:0]        stat1,
  input logic [7:0]        stat2
);

  assert_take_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !lock_q) |=> stat1[0]);

  assert_axis_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(x_out) <= SAT_LIM) && ($signed(x_out) >= -SAT_LIM));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data || rd_stat2) && !sample_vld && !lock_q) |=> (stat1[1:0] == 2'b00));

  assert_frozen_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !rd_stat2) |=> ($stable(x_out) && $stable(stat2)));

  assert_close_publishes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && rd_stat2 && pend_v && !sample_vld) |=> stat1[0]);

  assert_no_overrun_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_mode && !stat1[1]) |=> !stat1[1]);

  assert_drop_reported_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_mode && sample_vld && lock_q && pend_v) |=> stat1[1]);

  assert_fixed_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat2[2] && (stat2[7:4] == 4'b0) && (stat2[1:0] == 2'b0));

endmodule

bind mag_result_guard mag_result_guard_chk #(.AXIS_W(AXIS_W), .SAT_LIM(SAT_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .cont_mode(cont_mode), .sample_vld(sample_vld),
  .rd_data(rd_data), .rd_stat2(rd_stat2), .lock_q(lock_q), .pend_v(pend_v),
  .x_out(x_out), .stat1(stat1), .stat2(stat2)
);

// File: tb/mag_result_guard_tb.sv
module mag_result_guard_tb;
  localparam int IN_W = 18;
  localparam int AW   = 16;
  localparam int NV   = 14;

  function automatic logic [41:0] mk(input bit c, input bit v, input bit rd, input bit rs,
                                     input bit o, input int xi, input int ex,
                                     input bit d, input bit r, input bit h);
    return {c, v, rd, rs, o, 18'(xi), 16'(ex), d, r, h};
  endfunction

  // fields: cont, vld, rd_data, rd_stat2, ovf, x_in | exp x, drdy, dor, hofl
  localparam logic [41:0] VEC [NV] = '{
    mk(0,1,0,0,0,    100,    100, 1,0,0),  // R2 single-mode capture
    mk(0,1,0,0,1,    200,    200, 1,0,1),  // R9 R10 unread overwrite, no overrun
    mk(0,0,1,0,0,      0,    200, 0,0,1),  // R9 R4 data read, no window
    mk(0,1,0,0,0,    300,    300, 1,0,0),  // R9 sample after read not frozen
    mk(1,1,0,0,0,  40000,  32752, 1,1,0),  // R3 R7 clamp high, overrun
    mk(1,0,1,0,0,      0,  32752, 0,0,0),  // R5 R4 open window
    mk(1,1,0,0,1, -50000,  32752, 0,0,0),  // R5 held in window
    mk(1,1,0,0,0,     -5,  32752, 0,1,0),  // R8 buffer replaced, overrun
    mk(1,0,0,1,0,      0,     -5, 1,0,0),  // R6 R8 close publishes newest
    mk(1,0,1,0,0,      0,     -5, 0,0,0),  // R5 reopen
    mk(1,1,0,0,1,      7,     -5, 0,0,0),  // R5 buffered
    mk(1,1,0,1,0,      9,      9, 1,1,0),  // R11 direct take at close
    mk(1,1,0,0,0, -40000, -32752, 1,1,0),  // R3 clamp low
    mk(1,0,0,1,0,      0, -32752, 0,0,0)   // R4 trailing read clears
  };
  localparam string TAG [NV] = '{"R2","R9","R9","R9","R7","R5","R5","R8","R6","R5","R5","R11","R3","R4"};

  logic clk = 0, rst_n = 0;
  logic cont_mode = 0, sample_vld = 0, sample_ovf = 0;
  logic rd_data = 0, rd_stat1 = 0, rd_stat2 = 0;
  logic [IN_W-1:0] sample_x = '0, sample_y = '0, sample_z = '0;
  logic [AW-1:0] x_out, y_out, z_out;
  logic [7:0] stat1, stat2;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mag_result_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cont_mode(cont_mode), .sample_vld(sample_vld),
    .sample_x(sample_x), .sample_y(sample_y), .sample_z(sample_z), .sample_ovf(sample_ovf),
    .rd_data(rd_data), .rd_stat1(rd_stat1), .rd_stat2(rd_stat2),
    .x_out(x_out), .y_out(y_out), .z_out(z_out), .stat1(stat1), .stat2(stat2)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit c, input bit v, input bit rd, input bit rs, input bit r1,
                       input bit o, input logic [IN_W-1:0] xi);
    @(negedge clk);
    cont_mode = c; sample_vld = v; rd_data = rd; rd_stat2 = rs; rd_stat1 = r1;
    sample_ovf = o; sample_x = xi; sample_y = xi; sample_z = IN_W'(0) - xi;
    @(posedge clk); #1;
    sample_vld = 0; rd_data = 0; rd_stat2 = 0; rd_stat1 = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", {x_out, y_out, z_out, stat1, stat2}, {48'h0, 8'h00, 8'h04});
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic [41:0] e;
      logic [AW-1:0] ex;
      e = VEC[i];
      ex = e[18:3];
      drive(e[41], e[40], e[39], e[38], 1'b0, e[37], e[36:19]);
      check(TAG[i], {x_out, y_out, z_out, stat1, stat2},
            {ex, ex, AW'(0) - ex, 6'b0, e[1], e[2], 4'b0, e[0], 3'b100});
    end

    // R4 first-status read leaves flags alone
    drive(1, 1, 0, 0, 0, 1, 18'd1234);
    check("R10", stat2, 8'h0C);
    check("R2", x_out, 16'd1234);
    drive(1, 0, 0, 0, 1, 0, '0);
    check("R4", stat1, 8'h01);
    drive(1, 1, 0, 0, 1, 0, 18'd55);
    check("R7", stat1, 8'h03);
    drive(1, 0, 0, 0, 1, 0, '0);
    check("R4", stat1, 8'h03);

    // R10 overflow flag stays put while the window holds
    drive(1, 0, 1, 0, 0, 0, '0);
    drive(1, 1, 0, 0, 0, 1, 18'd66);
    check("R10", {stat2, x_out}, {8'h04, 16'd55});
    drive(1, 0, 0, 1, 0, 0, '0);
    check("R10", {stat2, x_out, stat1}, {8'h0C, 16'd66, 8'h01});

    // R1 synchronous reset mid-run
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1;
    check("R1", {x_out, stat1, stat2}, {16'h0, 8'h00, 8'h04});

    finish_run();
  end
endmodule